// File: doc/BRIEF.md
# Prefix Immediate Assembly Unit

This unit sits in the decode stage of a processor whose instructions are all 16 bits wide. The processor builds a wide constant from a run of prefix instructions followed by one instruction that uses the constant. Each prefix is an ordinary instruction that carries a 12-bit chunk. The unit shifts that chunk into an internal accumulator. When the using instruction is accepted, the unit joins the accumulator to the instruction's own short field and presents a 32-bit immediate together with a one-cycle valid strobe. The short field is 4 bits for ordinary instructions and 12 bits for branches.

The unit receives the instruction word, a class code produced by the upstream decoder, a valid flag and a stall flag. An instruction is accepted in a cycle when valid is high and stall is low. While a prefix is waiting for its consumer, the unit tells the interrupt logic to hold off, so that a prefix is never separated from the instruction it modifies. Reset is synchronous and active high.

Top module: `pfx_imm_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and the pending flag are cleared, and `imm_valid_o`, `irq_block_o` and `imm_o` read 0 after that edge. A prefix chain that is cut by reset has no effect on later immediates.
- R2: The class code on `insn_cls_i` is 0 for an instruction with no immediate, 1 for a prefix, 2 for a short consumer and 3 for a branch consumer. When no prefix is pending, a short consumer yields `insn_i[3:0]` sign-extended to 32 bits, and a branch yields `insn_i[11:0]` sign-extended to 32 bits.
- R3: After one prefix with chunk `insn_i[11:0]`, a short consumer yields the 16-bit value {chunk, field}, sign-extended from bit 11 of the chunk.
- R4: After one prefix, a branch consumer yields the 24-bit value {chunk, field}, sign-extended from bit 11 of the chunk.
- R5: Several prefixes are joined in arrival order, with the first chunk most significant. The result keeps its low 32 bits, and any bits above 32 are discarded. The sign comes from bit 11 of the first chunk.
- R6: Accepting a consumer clears the accumulator and the pending flag at the same edge, so the next consumer without a prefix yields only its own sign-extended field.
- R7: When `stall_i` is high, the instruction is not accepted. No prefix is recorded, no strobe is raised, and the pending state is kept.
- R8: `imm_valid_o` is high for exactly the one cycle after the edge that accepts a consumer, and `imm_o` holds the result during that cycle. A prefix never raises the strobe.
- R9: `irq_block_o` is high from the edge after an accepted prefix until the edge that accepts its consumer.
- R10: An accepted class-0 instruction leaves the pending chain untouched and raises no strobe.
- R11: When `insn_valid_i` is low, the unit ignores its other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid_i | input | 1 | Instruction present this cycle |
| stall_i | input | 1 | Decode stage held; nothing is accepted |
| insn_cls_i | input | 2 | Class: 0 none, 1 prefix, 2 short consumer, 3 branch consumer |
| insn_i | input | 16 | Instruction word; chunk and branch field in [11:0], short field in [3:0] |
| imm_o | output | 32 | Assembled immediate |
| imm_valid_o | output | 1 | One-cycle strobe for `imm_o` |
| irq_block_o | output | 1 | A prefix is pending; interrupts must wait |

## Verification
The hardest case to reach is a long prefix chain whose bits run past 32 while stalls and class-0 instructions are mixed in. The result then depends on which chunks were actually accepted and on the truncation. Chains this long only appear if many accepted prefixes come before a consumer. A random phase therefore weights the prefix class heavily and inserts stalls, class-0 instructions and idle cycles. A bench model computes each expected value arithmetically, reducing it modulo 2^32 after every chunk. Before that, a directed sweep covers chains of zero to three prefixes with boundary chunks against all short fields and a set of branch fields.

// File: rtl/pfx_imm_unit.sv
module pfx_imm_unit #(
  parameter int IMM_W   = 32,
  parameter int INSN_W  = 16,
  parameter int CHUNK_W = 12,
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid_i,
  input  logic              stall_i,
  input  logic [1:0]        insn_cls_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic [IMM_W-1:0]  imm_o,
  output logic              imm_valid_o,
  output logic              irq_block_o
);

  localparam logic [1:0] CLS_NONE  = 2'd0;
  localparam logic [1:0] CLS_PFX   = 2'd1;
  localparam logic [1:0] CLS_SHORT = 2'd2;
  localparam logic [1:0] CLS_BR    = 2'd3;

  logic [IMM_W-1:0] acc_q;
  logic             pend_q;

  wire                accept = insn_valid_i && !stall_i;
  wire [CHUNK_W-1:0]  chunk  = insn_i[CHUNK_W-1:0];
  wire [SHORT_W-1:0]  sfield = insn_i[SHORT_W-1:0];
  wire [LONG_W-1:0]   lfield = insn_i[LONG_W-1:0];

  logic unused_hi;
  assign unused_hi = &{1'b0, insn_i[INSN_W-1:LONG_W]};

  wire [IMM_W-1:0] acc_next = pend_q ? {acc_q[IMM_W-CHUNK_W-1:0], chunk}
                                     : {{(IMM_W-CHUNK_W){chunk[CHUNK_W-1]}}, chunk};
  wire [IMM_W-1:0] short_imm = pend_q ? {acc_q[IMM_W-SHORT_W-1:0], sfield}
                                      : {{(IMM_W-SHORT_W){sfield[SHORT_W-1]}}, sfield};
  wire [IMM_W-1:0] long_imm = pend_q ? {acc_q[IMM_W-LONG_W-1:0], lfield}
                                     : {{(IMM_W-LONG_W){lfield[LONG_W-1]}}, lfield};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= '0;
      pend_q      <= 1'b0;
      imm_o       <= '0;
      imm_valid_o <= 1'b0;
    end else begin
      imm_valid_o <= 1'b0;
      if (accept) begin
        case (insn_cls_i)
          CLS_PFX: begin
            acc_q  <= acc_next;
            pend_q <= 1'b1;
          end
          CLS_SHORT: begin
            imm_o       <= short_imm;
            imm_valid_o <= 1'b1;
            acc_q       <= '0;
            pend_q      <= 1'b0;
          end
          CLS_BR: begin
            imm_o       <= long_imm;
            imm_valid_o <= 1'b1;
            acc_q       <= '0;
            pend_q      <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign irq_block_o = pend_q;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> $stable(acc_q) && $stable(pend_q) && !imm_valid_o);

  // R8
  pfx_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && insn_cls_i == CLS_PFX) |=> !imm_valid_o && irq_block_o);

  // R6
  clear_on_use_chk: assert property (@(posedge clk) disable iff (rst)
    imm_valid_o |-> !pend_q && acc_q == '0);

  // R2
  plain_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && insn_cls_i == CLS_BR && !pend_q) |=>
      (imm_o[IMM_W-1:LONG_W-1] == '0 || imm_o[IMM_W-1:LONG_W-1] == '1));

  // R10
  none_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && insn_cls_i == CLS_NONE) |=> $stable(pend_q) && $stable(acc_q) && !imm_valid_o);

endmodule

// File: tb/pfx_imm_unit_tb.sv
module pfx_imm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0, stall = 1'b0;
  logic [1:0]  cls = 2'd0;
  logic [15:0] word = '0;
  logic [31:0] imm;
  logic        imm_v, irq_blk;

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] m_acc = '0;
  bit          m_pend = 0;
  int          m_npfx = 0;

  always #2 clk = ~clk;

  pfx_imm_unit dut_i (
    .clk(clk), .rst(rst), .insn_valid_i(valid), .stall_i(stall),
    .insn_cls_i(cls), .insn_i(word),
    .imm_o(imm), .imm_valid_o(imm_v), .irq_block_o(irq_blk)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] sext(logic [63:0] v, int w);
    return (v[w-1]) ? ((v - (64'd1 << w)) & 64'hFFFF_FFFF) : v;
  endfunction

  // drive one cycle at a negedge, compare at the next negedge
  task automatic step(bit v, bit s, logic [1:0] c, logic [15:0] w, string tag);
    bit          acc_ok = v && !s;
    bit          exp_v = 0;
    logic [63:0] exp_i = 0;
    string       t = tag;
    if (acc_ok && c == 2'd1) begin
      m_acc  = m_pend ? (((m_acc << 12) | 64'(w[11:0])) & 64'hFFFF_FFFF) : sext(64'(w[11:0]), 12);
      m_pend = 1;
      m_npfx++;
    end else if (acc_ok && c[1]) begin
      int fw = (c == 2'd3) ? 12 : 4;
      logic [63:0] f = (c == 2'd3) ? 64'(w[11:0]) : 64'(w[3:0]);
      exp_v = 1;
      exp_i = m_pend ? (((m_acc << fw) | f) & 64'hFFFF_FFFF) : sext(f, fw);
      if (t == "")
        t = (m_npfx == 0) ? "R2" : (m_npfx >= 2) ? "R5" : (c == 2'd3) ? "R4" : "R3";
      m_acc = 0; m_pend = 0; m_npfx = 0;
    end
    valid = v; stall = s; cls = c; word = w;
    @(negedge clk);
    chk("R8 strobe", 32'(imm_v), 32'(exp_v));
    chk("R9 irq_block", 32'(irq_blk), 32'(m_pend));
    if (exp_v) chk(t, imm, exp_i[31:0]);
    valid = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [11:0] cv [6] = '{12'h000, 12'h7FF, 12'h800, 12'hFFF, 12'h123, 12'hA5C};
  logic [11:0] bv [8] = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFF, 12'h3C5, 12'h9A0, 12'h555};

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 strobe", 32'(imm_v), 0);
    chk("R1 irq_block", 32'(irq_blk), 0);
    chk("R1 imm", imm, 0);

    // R2..R5 sweep
    for (int np = 0; np < 4; np++)
      for (int i = 0; i < 6; i++) begin
        for (int f = 0; f < 16; f++) begin
          for (int k = 0; k < np; k++) step(1, 0, 2'd1, {4'h1, cv[(i+k+f)%6]}, "");
          step(1, 0, 2'd2, {12'h0, 4'(f)}, "");
        end
        for (int b = 0; b < 8; b++) begin
          for (int k = 0; k < np; k++) step(1, 0, 2'd1, {4'h1, cv[(i+k+b)%6]}, "");
          step(1, 0, 2'd3, {4'h3, bv[b]}, "");
        end
      end

    // R6: clear after use
    step(1, 0, 2'd1, 16'h1ABC, "");
    step(1, 0, 2'd3, 16'h3123, "R4");
    step(1, 0, 2'd2, 16'h000F, "R6");

    // R5: truncation with three prefixes
    step(1, 0, 2'd1, 16'h1FFF, "");
    step(1, 0, 2'd1, 16'h1123, "");
    step(1, 0, 2'd1, 16'h1456, "");
    step(1, 0, 2'd3, 16'h3789, "R5");

    // R7 stall, R10 none, R11 invalid within a chain
    step(1, 1, 2'd1, 16'h1777, "");
    chk("R7 stalled prefix", 32'(irq_blk), 0);
    step(0, 0, 2'd1, 16'h1777, "");
    chk("R11 invalid prefix", 32'(irq_blk), 0);
    step(1, 0, 2'd1, 16'h1801, "");
    step(1, 1, 2'd2, 16'h0005, "");
    step(1, 0, 2'd0, 16'h0FFF, "");
    chk("R10 none keeps chain", 32'(irq_blk), 1);
    step(0, 0, 2'd3, 16'h3FFF, "");
    step(1, 0, 2'd2, 16'h0005, "R10");

    // R1: reset cuts a chain
    step(1, 0, 2'd1, 16'h1ABC, "");
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_acc = 0; m_pend = 0; m_npfx = 0;
    chk("R1 irq_block after reset", 32'(irq_blk), 0);
    step(1, 0, 2'd2, 16'h0007, "R1");

    // mixed random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [1:0] c = (r < 50) ? 2'd1 : (r < 70) ? 2'd2 : (r < 88) ? 2'd3 : 2'd0;
      step($urandom_range(0, 9) != 0, $urandom_range(0, 4) == 0, c, 16'($urandom), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule